// File: doc/BRIEF.md
# Busy-Gated Calendar Clock

This block keeps wall-clock time at one-second resolution: hours, minutes, seconds, day of month, month, a six-bit year offset and a leap-year flag. Software reaches it through a 32-bit register interface with four word locations: control, status, date and time. Time is kept on a slow low-frequency clock that is modelled inside the fast clock domain as a single-cycle enable, `slow_tick`. A one-second step occurs once every `TICKS_PER_SEC` enables.

Software writes to the control, date and time locations are not applied when they arrive. Each one is held in a pending register, and a busy flag for that location stays up until the next slow enable copies the value into the live state. Software must poll that flag before it trusts a readback. A write to control is accepted only when the upper half of the word carries a fixed key. The calendar uses the leap flag exactly as software last wrote it to decide the length of February, and it never recomputes that flag.

When the time rolls over at midnight, the date advances on the same enable. A reader that sees the time as zero can therefore re-read the date and get the new day.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, time reads 00:00:00 and date reads day 1, month 1, year offset 0 with the leap flag clear (word 0x00000101). Control reads zero, with all busy flags clear, and status reads zero.
- R2: The time word at offset 0x14 holds seconds in bits 5:0, minutes in 13:8 and hours in 20:16. The date word at 0x10 holds day in 4:0, month in 11:8, year offset in 21:16 and the leap flag in bit 22. Every other bit of both words reads zero, whatever was written.
- R3: A write to time, date or accepted control sets its busy bit in the control word: bit 8 for time, bit 9 for date, bit 7 for control. Readback keeps the old value until the first `slow_tick` after the write. On that tick the value is applied and the busy bit clears.
- R4: A second write to a location whose busy bit is still set replaces the pending value. Only the last value is applied.
- R5: A control write whose bits 31:16 differ from 0x16AA is ignored. It sets no busy bit and changes no control field.
- R6: The applied control fields read back at bit 0 (source select), bit 3 (drive setting) and bit 14 (auto-switch enable). Status at offset 0x04 bit 0 reports the applied source select.
- R7: Seconds advance by one on every `TICKS_PER_SEC`-th `slow_tick`. Applying a time write restarts that count.
- R8: A second step from 23:59:59 gives 00:00:00, and the date advances on the same tick.
- R9: Months 4, 6, 9 and 11 have 30 days and February has 28, or 29 when the leap flag is set. All other months have 31. The day after the last day is day 1 of the next month.
- R10: December 31 advances to January 1 and increments the year offset.
- R11: The leap flag keeps its written value across every date advance, including a year change.
- R12: Applying a time write of zero, even from 23:59:59, leaves the date unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| slow_tick | input | 1 | Single-cycle enable marking one low-frequency clock period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |

## Verification
Directed tests target these corner cases, and each one shows what a faulty design would do:
- **Midnight rollover.** The date must already show the next day in the same read that shows time zero. A design that carries the date one tick late would show the old date there.
- **Month ends.** The bench walks February with and without the leap flag, a 30-day month and December. A wrong month table would produce day 29 or 31 where it should not, and a missing year carry would leave the year offset unchanged.
- **Zero time write.** Writing zero at 23:59:59 must not advance the date. Treating the load as a rollover would advance it.
- **Rejected control write.** A write without the key must leave both control and busy untouched.
- **Overwrite while pending.** Two writes before one tick must apply only the last value.
- **Readback before the tick.** A value applied before its tick would show up in the readback taken before that tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned NREG   = 3;
  localparam int unsigned BSY_CTRL = 0;
  localparam int unsigned BSY_TIME = 1;
  localparam int unsigned BSY_DATE = 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DATE = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_TIME = 8'h14;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } rtc_time_t;

  typedef struct packed {
    logic       leap;
    logic [5:0] year;
    logic [3:0] mon;
    logic [4:0] day;
  } rtc_date_t;

  typedef struct packed {
    logic auto_sw;
    logic drive;
    logic src;
  } rtc_ctrl_t;

  function automatic rtc_time_t time_from_word(input logic [31:0] w);
    rtc_time_t t;
    t.hr  = w[20:16];
    t.min = w[13:8];
    t.sec = w[5:0];
    return t;
  endfunction

  function automatic logic [31:0] time_to_word(input rtc_time_t t);
    return {11'b0, t.hr, 2'b0, t.min, 2'b0, t.sec};
  endfunction

  function automatic rtc_date_t date_from_word(input logic [31:0] w);
    rtc_date_t d;
    d.leap = w[22];
    d.year = w[21:16];
    d.mon  = w[11:8];
    d.day  = w[4:0];
    return d;
  endfunction

  function automatic logic [31:0] date_to_word(input rtc_date_t d);
    return {9'b0, d.leap, d.year, 4'b0, d.mon, 3'b0, d.day};
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
    logic [4:0] n;
    case (mon)
      4'd2:                    n = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: n = 5'd30;
      default:                 n = 5'd31;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
  import rtc_cal_pkg::*;
#(
  parameter logic [15:0] KEY = 16'h16AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [NREG-1:0]   busy,
  output logic              apply_time,
  output logic              apply_date,
  output rtc_time_t         pend_time,
  output rtc_date_t         pend_date,
  output rtc_ctrl_t         ctrl
);

  logic [NREG-1:0] hit;
  logic [NREG-1:0] apply;
  logic [NREG-1:0] busy_d;
  rtc_ctrl_t       pend_ctrl, pend_ctrl_d, ctrl_d;
  rtc_time_t       pend_time_d;
  rtc_date_t       pend_date_d;

  always_comb begin
    hit           = '0;
    hit[BSY_CTRL] = wr_en && (addr == OFS_CTRL) && (wdata[31:16] == KEY);
    hit[BSY_TIME] = wr_en && (addr == OFS_TIME);
    hit[BSY_DATE] = wr_en && (addr == OFS_DATE);
  end

  // A write landing on a tick cycle stays pending for the next tick.
  for (genvar g = 0; g < NREG; g++) begin : g_flag
    assign apply[g]  = slow_tick & busy[g] & ~hit[g];
    assign busy_d[g] = hit[g] | (busy[g] & ~apply[g]);
  end

  assign apply_time = apply[BSY_TIME];
  assign apply_date = apply[BSY_DATE];

  always_comb begin
    pend_ctrl_d = pend_ctrl;
    pend_time_d = pend_time;
    pend_date_d = pend_date;
    ctrl_d      = ctrl;
    if (hit[BSY_CTRL]) begin
      pend_ctrl_d.src     = wdata[0];
      pend_ctrl_d.drive   = wdata[3];
      pend_ctrl_d.auto_sw = wdata[14];
    end
    if (hit[BSY_TIME]) pend_time_d = time_from_word(wdata);
    if (hit[BSY_DATE]) pend_date_d = date_from_word(wdata);
    if (apply[BSY_CTRL]) ctrl_d = pend_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= '0;
      pend_ctrl <= '0;
      pend_time <= '0;
      pend_date <= '0;
      ctrl      <= '0;
    end else begin
      busy      <= busy_d;
      pend_ctrl <= pend_ctrl_d;
      pend_time <= pend_time_d;
      pend_date <= pend_date_d;
      ctrl      <= ctrl_d;
    end
  end

endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      slow_tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cur,
  output logic      day_carry
);

  localparam int unsigned PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          sec_step;
  rtc_time_t     cur_d;

  always_comb begin
    pre_d    = pre_q;
    sec_step = 1'b0;
    if (load) begin
      pre_d = '0;
    end else if (slow_tick) begin
      if (pre_q == PRE_LAST) begin
        pre_d    = '0;
        sec_step = 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_comb begin
    cur_d     = cur;
    day_carry = 1'b0;
    if (load) begin
      cur_d = load_val;
    end else if (sec_step) begin
      if (cur.sec >= 6'd59) begin
        cur_d.sec = '0;
        if (cur.min >= 6'd59) begin
          cur_d.min = '0;
          if (cur.hr >= 5'd23) begin
            cur_d.hr  = '0;
            day_carry = 1'b1;
          end else begin
            cur_d.hr = cur.hr + 1'b1;
          end
        end else begin
          cur_d.min = cur.min + 1'b1;
        end
      end else begin
        cur_d.sec = cur.sec + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cur   <= '0;
    end else begin
      pre_q <= pre_d;
      cur   <= cur_d;
    end
  end

endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  rtc_date_t load_val,
  input  logic      carry,
  output rtc_date_t cur
);

  rtc_date_t  cur_d;
  logic [4:0] last_day;

  assign last_day = month_days(cur.mon, cur.leap);

  always_comb begin
    cur_d = cur;
    if (load) begin
      cur_d = load_val;
    end else if (carry) begin
      if (cur.day >= last_day) begin
        cur_d.day = 5'd1;
        if (cur.mon >= 4'd12) begin
          cur_d.mon  = 4'd1;
          cur_d.year = cur.year + 1'b1;
        end else begin
          cur_d.mon = cur.mon + 1'b1;
        end
      end else begin
        cur_d.day = cur.day + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur.leap <= 1'b0;
      cur.year <= '0;
      cur.mon  <= 4'd1;
      cur.day  <= 5'd1;
    end else begin
      cur <= cur_d;
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter logic [15:0] KEY           = 16'h16AA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);

  logic [NREG-1:0] busy;
  logic            apply_time, apply_date, day_carry;
  rtc_time_t       pend_time, cur_time;
  rtc_date_t       pend_date, cur_date;
  rtc_ctrl_t       ctrl;

  rtc_bus_regs #(.KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .busy(busy), .apply_time(apply_time),
    .apply_date(apply_date), .pend_time(pend_time), .pend_date(pend_date),
    .ctrl(ctrl)
  );

  rtc_time_cnt #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_time (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .load(apply_time),
    .load_val(pend_time), .cur(cur_time), .day_carry(day_carry)
  );

  rtc_date_cnt u_date (
    .clk(clk), .rst_n(rst_n), .load(apply_date), .load_val(pend_date),
    .carry(day_carry), .cur(cur_date)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: begin
        rdata[0]   = ctrl.src;
        rdata[3]   = ctrl.drive;
        rdata[14]  = ctrl.auto_sw;
        rdata[7]   = busy[BSY_CTRL];
        rdata[8]   = busy[BSY_TIME];
        rdata[9]   = busy[BSY_DATE];
      end
      OFS_STAT: rdata[0] = ctrl.src;
      OFS_DATE: rdata = date_to_word(cur_date);
      OFS_TIME: rdata = time_to_word(cur_time);
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
#(
  parameter logic [15:0] KEY = 16'h16AA
) (
  input logic            clk,
  input logic            rst_n,
  input logic            slow_tick,
  input logic            wr_en,
  input logic [7:0]      addr,
  input logic [31:0]     wdata,
  input logic [NREG-1:0] busy,
  input rtc_time_t       cur_time,
  input rtc_date_t       cur_date
);

  localparam rtc_time_t T_LAST = '{hr: 5'd23, min: 6'd59, sec: 6'd59};

  assert_busy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_TIME) |=> busy[BSY_TIME]);

  assert_busy_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_tick && !(wr_en && addr == OFS_TIME)) |=> !busy[BSY_TIME]);

  assert_key_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CTRL && wdata[31:16] != KEY && !busy[BSY_CTRL])
      |=> !busy[BSY_CTRL]);

  assert_time_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick |=> $stable(cur_time));

  assert_date_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick |=> $stable(cur_date));

  assert_rollover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_tick && !busy[BSY_TIME] && !busy[BSY_DATE] && cur_time == T_LAST)
      |=> ((cur_time != '0) || (cur_date != $past(cur_date))));

  assert_leap_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_tick && !busy[BSY_DATE]) |=> (cur_date.leap == $past(cur_date.leap)));

endmodule

bind rtc_calendar rtc_calendar_chk #(.KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .busy(busy), .cur_time(cur_time),
  .cur_date(cur_date)
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;

  localparam int TPS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  rtc_calendar #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic set_clock(input logic [31:0] d, input logic [31:0] t);
    wr(8'h10, d);
    wr(8'h14, t);
    tick(1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h14, v); check("R1 time", v, 32'h0);
    rd(8'h10, v); check("R1 date", v, 32'h00000101);
    rd(8'h00, v); check("R1 ctrl", v, 32'h0);
    rd(8'h04, v); check("R1 status", v, 32'h0);
  endtask

  task automatic t_pending_and_mask;
    logic [31:0] v;
    wr(8'h14, 32'hFFECE2F8);
    rd(8'h00, v); check("R3 time busy bit 8", {22'b0, v[9:7]}, 32'h2);
    rd(8'h14, v); check("R3 old time before tick", v, 32'h0);
    tick(1);
    rd(8'h00, v); check("R3 busy clear", {22'b0, v[9:7]}, 32'h0);
    rd(8'h14, v); check("R2 time masked", v, 32'h000C2238);
    wr(8'h10, 32'hFFB5_F9E7);
    rd(8'h00, v); check("R3 date busy bit 9", {22'b0, v[9:7]}, 32'h4);
    tick(1);
    rd(8'h10, v); check("R2 date masked", v, 32'h00350907);
  endtask

  task automatic t_overwrite;
    logic [31:0] v;
    wr(8'h14, 32'h00010203);
    wr(8'h14, 32'h00040506);
    tick(1);
    rd(8'h14, v); check("R4 last value applied", v, 32'h00040506);
  endtask

  task automatic t_control;
    logic [31:0] v;
    wr(8'h00, 32'h00004009);
    rd(8'h00, v); check("R5 no busy without key", v, 32'h0);
    tick(1);
    rd(8'h00, v); check("R5 unkeyed ignored", v, 32'h0);
    wr(8'h00, 32'h16AA4009);
    rd(8'h00, v); check("R3 ctrl busy bit 7", v, 32'h00000080);
    tick(1);
    rd(8'h00, v); check("R6 ctrl fields", v, 32'h00004009);
    rd(8'h04, v); check("R6 status source", v, 32'h1);
    wr(8'h00, 32'h16AB0000);
    tick(1);
    rd(8'h00, v); check("R5 wrong key ignored", v, 32'h00004009);
  endtask

  task automatic t_seconds;
    logic [31:0] v;
    set_clock(32'h000E0305, 32'h000C2238);
    tick(TPS - 1);
    rd(8'h14, v); check("R7 no step early", v, 32'h000C2238);
    tick(1);
    rd(8'h14, v); check("R7 one second", v, 32'h000C2239);
    tick(TPS);
    rd(8'h14, v); check("R7 next second", v, 32'h000C223A);
  endtask

  task automatic t_roll(input string req, input logic [31:0] d0, input logic [31:0] d1);
    logic [31:0] v;
    set_clock(d0, 32'h00173B3B);
    tick(TPS);
    rd(8'h14, v); check({req, " time zero"}, v, 32'h0);
    rd(8'h10, v); check(req, v, d1);
  endtask

  task automatic t_zero_write;
    logic [31:0] v;
    set_clock(32'h000E011F, 32'h00173B3B);
    wr(8'h14, 32'h0);
    tick(1);
    rd(8'h14, v); check("R12 time zero", v, 32'h0);
    rd(8'h10, v); check("R12 date unchanged", v, 32'h000E011F);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_pending_and_mask;
    t_overwrite;
    t_control;
    t_seconds;
    t_roll("R8 Jan31 to Feb1", 32'h000E011F, 32'h000E0201);
    t_roll("R9 Feb28 leap", 32'h004E021C, 32'h004E021D);
    t_roll("R9 Feb28 plain", 32'h000E021C, 32'h000E0301);
    t_roll("R9 Feb29 leap", 32'h004E021D, 32'h004E0301);
    t_roll("R9 Apr30", 32'h000E041E, 32'h000E0501);
    t_roll("R10 R11 Dec31", 32'h00450C1F, 32'h00460101);
    t_zero_write;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule